// File: doc/BRIEF.md
# Stretched Reset Generator

This block produces a single active-low reset for a subsystem from several fault sources. The sources are a manual reset pin, an under-voltage flag and an over-voltage flag per supply rail, and a one-cycle expiry pulse from a long-period supervision timer. Each rail has two enable bits, one for its under-voltage flag and one for its over-voltage flag. The monitors that produce the flags keep running whether or not a flag is enabled. A disabled flag simply cannot pull reset.

The reset is held while any enabled source is active. After the last source clears, the reset stays asserted until a programmable number of tick strobes has been counted. If a source returns during that countdown, the count starts again from zero.

The manual reset pin is asynchronous and passes through a flop synchronizer before use. When the logic leaves its own reset, the output starts asserted and runs one full timeout before it releases. A status output reports that a reset is in progress, so that neighbouring logic can hold off.

Top module: `rst_gen_stretch`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `rst_out_n` is 0 and `rst_busy` is 1. `rst_busy` is always the inverse of `rst_out_n`.
- R2: Once no source is active, `rst_out_n` rises on the first clock edge at which the number of tick strobes counted since the last active-source cycle is at least `timeout_cfg`. With a strobe on every cycle and a timeout of N, this is the (N+1)th edge after the sources clear, and also after `rst_n` rises.
- R3: A low level on `mr_n` forces `rst_out_n` low whatever the enable bits are set to. Because of the two synchronizer flops, the output falls on the third clock edge after the pin falls.
- R4: `rst_out_n` stays low for as long as `mr_n` is low. After `mr_n` rises it stays low for the timeout as well. With a strobe on every cycle it rises on the (N+3)th edge after the pin rises.
- R5: When `uv_flag[i]` and `uv_en[i]` are both 1, `rst_out_n` is 0 after the next clock edge.
- R6: A flag whose enable bit is 0 has no effect on `rst_out_n`. An under-voltage flag is not unblocked by the over-voltage enable of the same rail.
- R7: When `ov_flag[i]` and `ov_en[i]` are both 1, `rst_out_n` is 0 after the next clock edge.
- R8: A one-cycle pulse on `ldog_expire` asserts the reset on the next edge and runs a full timeout. With a strobe on every cycle, the output rises on the (N+2)th edge counted from the edge that samples the pulse.
- R9: A source that reasserts during the countdown restarts the count from zero.
- R10: With `timeout_cfg` equal to 0, `rst_out_n` rises on the first edge after the sources clear.
- R11: The countdown advances only on cycles where `tick` is 1. With `tick` held at 0, the reset never releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's logic |
| mr_n | input | 1 | Asynchronous manual reset pin, active low |
| uv_flag | input | NRAIL | Under-voltage flag, one bit per rail |
| ov_flag | input | NRAIL | Over-voltage flag, one bit per rail |
| uv_en | input | NRAIL | Enable bits: allow each under-voltage flag to cause a reset |
| ov_en | input | NRAIL | Enable bits: allow each over-voltage flag to cause a reset |
| ldog_expire | input | 1 | One-cycle pulse when the long supervision timer expires |
| tick | input | 1 | Time-base strobe that advances the release countdown |
| timeout_cfg | input | TW | Release timeout, in tick strobes |
| rst_out_n | output | 1 | Generated reset, active low |
| rst_busy | output | 1 | High while a reset is in progress |

## Verification
The bench counts clock edges exactly at each transition of the manual reset. An extra or missing synchronizer stage, or an off-by-one in the stretch counter, would move the edge at which the output changes by one cycle.

Countdown restart is probed by reasserting a source partway through the stretch. A timer that froze, or resumed from where it stopped, would release the reset early.

The enable bits are crossed between under-voltage and over-voltage on one rail. A mask applied per rail rather than per flag would let the crossed flag through.

A zero timeout, a tick held at 0, a single-cycle expiry pulse and a slow tick are also driven. These expose a counter that needs a strobe before it can release, or one that counts clocks rather than strobes.

// File: rtl/rg_pkg.sv
package rg_pkg;
   typedef struct packed {
      logic manual;
      logic volt;
      logic ldog;
   } rg_src_t;

   localparam int unsigned RG_MIN_SYNC = 2;
endpackage

// File: rtl/rg_sync.sv
module rg_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   import rg_pkg::*;

   generate
      if (STAGES < RG_MIN_SYNC) begin : g_bad_stages
         $error("rg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rg_src_combine.sv
module rg_src_combine #(
   parameter int unsigned NRAIL   = 4,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mr_s_n,
   input  logic [NRAIL-1:0]  uv_flag,
   input  logic [NRAIL-1:0]  ov_flag,
   input  logic [NRAIL-1:0]  uv_en,
   input  logic [NRAIL-1:0]  ov_en,
   input  logic              ldog_expire,
   output rg_pkg::rg_src_t   src
);
   import rg_pkg::*;

   generate
      if (NRAIL < 1) begin : g_bad_nrail
         $error("rg_src_combine: NRAIL must be at least 1");
      end
   endgenerate

   logic [NRAIL-1:0] rail_hit;

   genvar gi;
   generate
      for (gi = 0; gi < NRAIL; gi++) begin : g_rail
         assign rail_hit[gi] = (uv_flag[gi] & uv_en[gi]) | (ov_flag[gi] & ov_en[gi]);
      end
   endgenerate

   rg_src_t src_c;
   always_comb begin
      src_c.manual = ~mr_s_n;
      src_c.volt   = |rail_hit;
      src_c.ldog   = ldog_expire;
   end

   generate
      if (REG_OUT) begin : g_reg
         rg_src_t src_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) src_q <= '0;
            else        src_q <= src_c;
         end
         assign src = src_q;
      end else begin : g_comb
         assign src = src_c;
      end
   endgenerate

   // R6: with every enable cleared, the voltage path stays quiet
   p_mask_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((uv_en == '0) && (ov_en == '0)) |-> !src_c.volt);
endmodule

// File: rtl/rg_stretch.sv
module rg_stretch #(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          src_any,
   input  logic          tick,
   input  logic [TW-1:0] timeout_cfg,
   output logic          asserted
);
   generate
      if (TW < 1) begin : g_bad_tw
         $error("rg_stretch: TW must be at least 1");
      end
   endgenerate

   logic [TW-1:0] cnt;
   logic          done;

   assign done = (cnt >= timeout_cfg);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asserted <= 1'b1;
         cnt      <= '0;
      end else if (src_any) begin
         asserted <= 1'b1;
         cnt      <= '0;
      end else if (asserted) begin
         if (done) begin
            asserted <= 1'b0;
            cnt      <= '0;
         end else if (tick) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R5: any active source holds the reset on the following cycle
   p_src_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      src_any |=> asserted);
   // R9: an active source restarts the countdown
   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      src_any |=> (cnt == '0));
   // R2: release only follows a quiet cycle
   p_quiet_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(asserted) |-> $past(!src_any));
   // R11: without a strobe the count holds
   p_tick_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !src_any && asserted && !done) |=> $stable(cnt));
endmodule

// File: rtl/rst_gen_stretch.sv
module rst_gen_stretch #(
   parameter int unsigned NRAIL       = 4,
   parameter int unsigned TW          = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SRC_REG     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mr_n,
   input  logic [NRAIL-1:0] uv_flag,
   input  logic [NRAIL-1:0] ov_flag,
   input  logic [NRAIL-1:0] uv_en,
   input  logic [NRAIL-1:0] ov_en,
   input  logic             ldog_expire,
   input  logic             tick,
   input  logic [TW-1:0]    timeout_cfg,
   output logic             rst_out_n,
   output logic             rst_busy
);
   import rg_pkg::*;

   logic    mr_s_n;
   rg_src_t src;
   logic    src_any;
   logic    asserted;

   rg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mr_sync (
      .clk(clk), .rst_n(rst_n), .d(mr_n), .q(mr_s_n));

   rg_src_combine #(.NRAIL(NRAIL), .REG_OUT(SRC_REG)) u_combine (
      .clk(clk), .rst_n(rst_n), .mr_s_n(mr_s_n),
      .uv_flag(uv_flag), .ov_flag(ov_flag), .uv_en(uv_en), .ov_en(ov_en),
      .ldog_expire(ldog_expire), .src(src));

   assign src_any = src.manual | src.volt | src.ldog;

   rg_stretch #(.TW(TW)) u_stretch (
      .clk(clk), .rst_n(rst_n), .src_any(src_any), .tick(tick),
      .timeout_cfg(timeout_cfg), .asserted(asserted));

   assign rst_out_n = ~asserted;
   assign rst_busy  = asserted;

   // R3: synchronized manual reset forces the output low regardless of masks
   p_manual_forces_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mr_s_n && !SRC_REG) |=> !rst_out_n);
   // R8: expiry pulse asserts the reset
   p_ldog_forces_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ldog_expire && !SRC_REG) |=> !rst_out_n);
   // R4: output cannot rise while the manual pin is seen low
   p_mr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out_n) |-> $past(mr_s_n));
endmodule

// File: tb/sim_rst_gen_stretch.sv
module sim_rst_gen_stretch;
   localparam int  CLK_PER = 10;
   localparam int  NRAIL   = 4;
   localparam int  TW      = 8;
   localparam int  N       = 5;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             mr_n;
   logic [NRAIL-1:0] uv_flag, ov_flag, uv_en, ov_en;
   logic             ldog_expire;
   logic             tick;
   logic [TW-1:0]    timeout_cfg;
   logic             rst_out_n, rst_busy;

   int n_chk  = 0;
   int n_fail = 0;
   int tick_div = 1;
   int cyc = 0;

   always #(CLK_PER/2) clk = ~clk;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (tick_div == 0)      tick <= 1'b0;
      else if (tick_div == 1) tick <= 1'b1;
      else                    tick <= ((cyc % tick_div) == 0);
   end

   rst_gen_stretch #(.NRAIL(NRAIL), .TW(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .mr_n(mr_n), .uv_flag(uv_flag), .ov_flag(ov_flag),
      .uv_en(uv_en), .ov_en(ov_en), .ldog_expire(ldog_expire), .tick(tick),
      .timeout_cfg(timeout_cfg), .rst_out_n(rst_out_n), .rst_busy(rst_busy));

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: rst_out_n actual=%b expected=%b at t=%0t", req, act, exp, $time);
      end
      if (rst_busy !== ~rst_out_n) begin
         n_fail++;
         $display("FAIL R1: rst_busy actual=%b expected=%b", rst_busy, ~rst_out_n);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset_r1_r2();
      rst_n = 1'b0; mr_n = 1'b1; uv_flag = '0; ov_flag = '0;
      uv_en = '0; ov_en = '0; ldog_expire = 1'b0; timeout_cfg = TW'(N);
      tick_div = 1;
      step(3);
      check("R1 in reset", rst_out_n, 1'b0);
      rst_n = 1'b1;
      step(N);
      check("R2 after power-on, before timeout", rst_out_n, 1'b0);
      step(1);
      check("R2 released after power-on timeout", rst_out_n, 1'b1);
   endtask

   task automatic t_manual_r3_r4();
      mr_n = 1'b0;
      step(2);
      check("R3 two edges after mr fall", rst_out_n, 1'b1);
      step(1);
      check("R3 three edges after mr fall, masks zero", rst_out_n, 1'b0);
      step(20);
      check("R4 held while mr low", rst_out_n, 1'b0);
      mr_n = 1'b1;
      step(N + 2);
      check("R4 still stretched", rst_out_n, 1'b0);
      step(1);
      check("R4 released after stretch", rst_out_n, 1'b1);
   endtask

   task automatic t_uv_r5();
      uv_en = 4'b0100; uv_flag = 4'b0100;
      step(1);
      check("R5 enabled uv rail 2", rst_out_n, 1'b0);
      uv_flag = '0;
      step(N);
      check("R2 uv stretch before end", rst_out_n, 1'b0);
      step(1);
      check("R2 uv stretch end", rst_out_n, 1'b1);
      uv_en = '0;
   endtask

   task automatic t_mask_r6();
      uv_flag = '1; ov_flag = '1;
      step(10);
      check("R6 all flags masked", rst_out_n, 1'b1);
      ov_flag = '0; uv_flag = 4'b0010; ov_en = 4'b0010;
      step(10);
      check("R6 uv not unblocked by ov enable", rst_out_n, 1'b1);
      uv_flag = '0; ov_en = '0;
   endtask

   task automatic t_ov_r7();
      ov_en = 4'b1000; ov_flag = 4'b1000;
      step(1);
      check("R7 enabled ov rail 3", rst_out_n, 1'b0);
      ov_flag = '0;
      step(N + 1);
      check("R7 recovers", rst_out_n, 1'b1);
      ov_en = '0;
   endtask

   task automatic t_ldog_r8();
      ldog_expire = 1'b1;
      step(1);
      ldog_expire = 1'b0;
      check("R8 pulse asserts", rst_out_n, 1'b0);
      step(N);
      check("R8 still stretched", rst_out_n, 1'b0);
      step(1);
      check("R8 released", rst_out_n, 1'b1);
   endtask

   task automatic t_restart_r9();
      uv_en = 4'b0001; uv_flag = 4'b0001;
      step(1);
      uv_flag = '0;
      step(3);
      uv_flag = 4'b0001;
      step(1);
      uv_flag = '0;
      step(N);
      check("R9 restarted count not done", rst_out_n, 1'b0);
      step(1);
      check("R9 restarted count done", rst_out_n, 1'b1);
      uv_en = '0;
   endtask

   task automatic t_zero_r10();
      timeout_cfg = '0;
      ov_en = 4'b0001; ov_flag = 4'b0001;
      step(2);
      ov_flag = '0;
      check("R10 held before edge", rst_out_n, 1'b0);
      step(1);
      check("R10 zero timeout release", rst_out_n, 1'b1);
      ov_en = '0; timeout_cfg = TW'(N);
   endtask

   task automatic t_tick_r11();
      tick_div = 0;
      step(2);
      ldog_expire = 1'b1;
      step(1);
      ldog_expire = 1'b0;
      step(50);
      check("R11 no strobes, no release", rst_out_n, 1'b0);
      tick_div = 4;
      step(4 * N - 4);
      check("R11 slow tick not yet", rst_out_n, 1'b0);
      step(8);
      check("R11 slow tick released", rst_out_n, 1'b1);
      tick_div = 1;
   endtask

   initial begin
      t_reset_r1_r2();
      t_manual_r3_r4();
      t_uv_r5();
      t_mask_r6();
      t_ov_r7();
      t_ldog_r8();
      t_restart_r9();
      t_zero_r10();
      t_tick_r11();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule